// File: doc/BRIEF.md
# Transmit/Receive Bus Arbiter with Weighted Round-Robin

This block decides which of two DMA engines, one moving transmit data and one moving receive data, owns the shared system bus. Each engine raises a request line. When its transaction ends, it pulses a done line. The block answers with a one-hot grant. A grant lasts until the owning engine signals done. The block takes a new decision only while the bus is idle.

Three configuration inputs set the policy. A mode bit chooses between weighted round-robin and strict fixed priority. A direction bit names the favoured side, which is transmit when the bit is set and receive when it is clear. A 2-bit ratio code sets how many grants in a row the favoured side may take before the other side gets one contested grant. The code 0 gives 1:1, code 1 gives 2:1, code 2 gives 3:1 and code 3 gives 4:1. The block reads the configuration only when it makes a decision, so changing it during a held grant has no effect until the next decision.

Top module: `txrx_bus_arbiter`

## Requirements
- R1: After reset, both grants are low.
- R2: A grant output is high only for a side whose request was high at the clock edge that issued the grant. At most one grant is high at a time. A grant is issued one clock edge after the request is seen while the bus is idle.
- R3: A grant stays high until its owner pulses done. The grant then drops at that clock edge. The bus stays idle for at least one cycle before the next grant.
- R4: A done pulse from the side that does not hold the grant is ignored. A request from that side during a held grant is also ignored. Neither ends the grant nor produces a second grant.
- R5: Weighted mode (mode bit 0), with both sides requesting: the favoured side wins until it has taken ratio code + 1 contested grants in a row. The other side then wins one contested grant, and the count restarts from zero.
- R6: The direction bit picks the favoured side: transmit when it is 1 and receive when it is 0. The ratio is therefore Tx:Rx or Rx:Tx.
- R7: Fixed mode (mode bit 1): when both sides request, the favoured side always wins and the ratio code has no effect.
- R8: When only one side requests, it is granted whatever the ratio state. This uncontested grant neither advances nor clears the run count of the favoured side.
- R9: Changes to the mode, direction or ratio inputs during a held grant do not alter that grant. They apply at the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit engine requests the bus |
| tx_done | input | 1 | Transmit engine ends its transaction |
| rx_req | input | 1 | Receive engine requests the bus |
| rx_done | input | 1 | Receive engine ends its transaction |
| cfg_ratio | input | 2 | Ratio code: favoured side gets code+1 grants per one of the other |
| cfg_tx_pref | input | 1 | 1 = transmit favoured, 0 = receive favoured |
| cfg_fixed | input | 1 | 1 = strict fixed priority, 0 = weighted round-robin |
| tx_gnt | output | 1 | Bus granted to transmit engine |
| rx_gnt | output | 1 | Bus granted to receive engine |

## Verification
The hardest state to reach from the ports is a run count that sits part way through the ratio window when an uncontested grant to the other side arrives. Only the grant sequence shows that this grant left the count untouched. The stimulus first gives the favoured side one contested win. It then grants the other side alone and follows with contested rounds. The order of the later winners shows whether the count survived. A second scenario shortens the ratio code while the count is mid-run, to confirm that the new limit applies at the next decision.

// File: rtl/txrx_arb_pkg.sv
package txrx_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_TX   = 2'b01,
    OWN_RX   = 2'b10
  } owner_t;
endpackage

// File: rtl/txrx_arb_pick.sv
module txrx_arb_pick
  import txrx_arb_pkg::*;
#(
  parameter int RATIO_W = 2,
  parameter int CNT_W   = 3
) (
  input  logic               tx_req,
  input  logic               rx_req,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               tx_pref,
  input  logic               fixed,
  input  logic [CNT_W-1:0]   streak,
  output owner_t             winner,
  output logic               bump,
  output logic               restart
);
  logic             both;
  logic             limit_hit;
  logic [CNT_W-1:0] limit;
  owner_t           fav, oth;

  always_comb begin
    both      = tx_req & rx_req;
    limit     = CNT_W'(ratio) + CNT_W'(1);
    limit_hit = (streak >= limit);
    fav       = tx_pref ? OWN_TX : OWN_RX;
    oth       = tx_pref ? OWN_RX : OWN_TX;
    winner    = OWN_NONE;
    bump      = 1'b0;
    restart   = 1'b0;
    if (both) begin
      if (fixed) begin
        winner = fav;
      end else if (limit_hit) begin
        winner  = oth;
        restart = 1'b1;
      end else begin
        winner = fav;
        bump   = 1'b1;
      end
    end else if (tx_req) begin
      winner = OWN_TX;
    end else if (rx_req) begin
      winner = OWN_RX;
    end
  end
endmodule

// File: rtl/txrx_arb_streak.sv
module txrx_arb_streak #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump_en,
  input  logic             restart_en,
  output logic [CNT_W-1:0] streak
);
  logic [CNT_W-1:0] streak_nxt;
  logic             streak_en;

  always_comb begin
    streak_en  = bump_en | restart_en;
    streak_nxt = restart_en ? '0 : streak + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         streak <= '0;
    else if (streak_en) streak <= streak_nxt;
  end
endmodule

// File: rtl/txrx_arb_hold.sv
module txrx_arb_hold
  import txrx_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  owner_t winner,
  input  logic   tx_done,
  input  logic   rx_done,
  output owner_t owner,
  output logic   idle
);
  owner_t owner_nxt;
  logic   owner_en;

  always_comb begin
    idle      = (owner == OWN_NONE);
    owner_nxt = owner;
    owner_en  = 1'b0;
    unique case (owner)
      OWN_NONE: begin
        owner_nxt = winner;
        owner_en  = (winner != OWN_NONE);
      end
      OWN_TX: begin
        owner_nxt = OWN_NONE;
        owner_en  = tx_done;
      end
      OWN_RX: begin
        owner_nxt = OWN_NONE;
        owner_en  = rx_done;
      end
      default: begin
        owner_nxt = OWN_NONE;
        owner_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner <= OWN_NONE;
    else if (owner_en) owner <= owner_nxt;
  end
endmodule

// File: rtl/txrx_bus_arbiter.sv
module txrx_bus_arbiter
  import txrx_arb_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_req,
  input  logic               tx_done,
  input  logic               rx_req,
  input  logic               rx_done,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               cfg_tx_pref,
  input  logic               cfg_fixed,
  output logic               tx_gnt,
  output logic               rx_gnt
);
  localparam int MAX_RUN = 2 ** RATIO_W;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  owner_t           winner, owner;
  logic             bump, restart, idle;
  logic [CNT_W-1:0] streak;

  txrx_arb_pick #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_pick (
    .tx_req (tx_req),
    .rx_req (rx_req),
    .ratio  (cfg_ratio),
    .tx_pref(cfg_tx_pref),
    .fixed  (cfg_fixed),
    .streak (streak),
    .winner (winner),
    .bump   (bump),
    .restart(restart)
  );

  txrx_arb_streak #(.CNT_W(CNT_W)) u_streak (
    .clk       (clk),
    .rst_n     (rst_n),
    .bump_en   (bump & idle),
    .restart_en(restart & idle),
    .streak    (streak)
  );

  txrx_arb_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .winner (winner),
    .tx_done(tx_done),
    .rx_done(rx_done),
    .owner  (owner),
    .idle   (idle)
  );

  always_comb begin
    tx_gnt = (owner == OWN_TX);
    rx_gnt = (owner == OWN_RX);
  end
endmodule

// File: rtl/txrx_arb_checker.sv
module txrx_arb_checker #(
  parameter int RATIO_W = 2,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_req,
  input logic             tx_done,
  input logic             rx_req,
  input logic             rx_done,
  input logic             cfg_tx_pref,
  input logic             cfg_fixed,
  input logic             tx_gnt,
  input logic             rx_gnt,
  input logic [CNT_W-1:0] streak
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_gnt, rx_gnt})); // R2
  AST_TX_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_gnt) |-> $past(tx_req)); // R2
  AST_RX_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_gnt) |-> $past(rx_req)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && !tx_done) |=> tx_gnt); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_gnt && !rx_done) |=> rx_gnt); // R3
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && tx_done) |=> !tx_gnt && !rx_gnt); // R3
  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_gnt && rx_done) |=> !tx_gnt && !rx_gnt); // R3
  AST_FIXED_PREF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fixed && !tx_gnt && !rx_gnt && tx_req && rx_req)
      |=> (cfg_tx_pref ? tx_gnt : rx_gnt) == 1'b1); // R7
  AST_STREAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    streak <= CNT_W'(2 ** RATIO_W)); // R5
endmodule

bind txrx_bus_arbiter txrx_arb_checker #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_req     (tx_req),
  .tx_done    (tx_done),
  .rx_req     (rx_req),
  .rx_done    (rx_done),
  .cfg_tx_pref(cfg_tx_pref),
  .cfg_fixed  (cfg_fixed),
  .tx_gnt     (tx_gnt),
  .rx_gnt     (rx_gnt),
  .streak     (streak)
);

// File: tb/tb_txrx_bus_arbiter.sv
module tb_txrx_bus_arbiter;
  logic       clk, rst_n;
  logic       tx_req, tx_done, rx_req, rx_done;
  logic [1:0] cfg_ratio;
  logic       cfg_tx_pref, cfg_fixed;
  logic       tx_gnt, rx_gnt;
  int         n_run, n_fail;

  txrx_bus_arbiter #(.RATIO_W(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .tx_req(tx_req), .tx_done(tx_done),
    .rx_req(rx_req), .rx_done(rx_done),
    .cfg_ratio(cfg_ratio), .cfg_tx_pref(cfg_tx_pref), .cfg_fixed(cfg_fixed),
    .tx_gnt(tx_gnt), .rx_gnt(rx_gnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {tx_gnt,rx_gnt} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] ratio, input logic pref, input logic fixed);
    @(negedge clk);
    rst_n = 1'b0; tx_req = 0; rx_req = 0; tx_done = 0; rx_done = 0;
    cfg_ratio = ratio; cfg_tx_pref = pref; cfg_fixed = fixed;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One arbitration round: request, see grant one edge later, release with done.
  task automatic round(input string req, input logic t, input logic r, input logic [1:0] exp);
    tx_req = t; rx_req = r;
    @(negedge clk);
    check(req, {tx_gnt, rx_gnt}, exp);
    tx_req = 0; rx_req = 0;
    tx_done = tx_gnt; rx_done = rx_gnt;
    @(negedge clk);
    tx_done = 0; rx_done = 0;
    check({req, " release R3"}, {tx_gnt, rx_gnt}, 2'b00);
  endtask

  task automatic t_reset();
    do_reset(2'd0, 1'b0, 1'b0);
    check("R1 reset", {tx_gnt, rx_gnt}, 2'b00);
  endtask

  task automatic t_ratio_rx(input logic [1:0] code);
    do_reset(code, 1'b0, 1'b0);
    for (int k = 0; k < 2 * (code + 2); k++) begin
      logic [1:0] e;
      e = ((k % (code + 2)) == code + 1) ? 2'b10 : 2'b01;
      round("R5 R6 weighted rx favoured", 1'b1, 1'b1, e);
    end
  endtask

  task automatic t_ratio_tx();
    do_reset(2'd3, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++)
      round("R5 R6 weighted tx favoured 4:1", 1'b1, 1'b1, (k == 4) ? 2'b01 : 2'b10);
  endtask

  task automatic t_uncontested();
    do_reset(2'd1, 1'b0, 1'b0);
    round("R8 contested 1", 1, 1, 2'b01);
    round("R8 tx alone", 1, 0, 2'b10);
    round("R8 rx alone", 0, 1, 2'b01);
    round("R8 contested 2", 1, 1, 2'b01);
    round("R8 limit reached", 1, 1, 2'b10);
  endtask

  task automatic t_fixed();
    do_reset(2'd0, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) round("R7 fixed tx", 1, 1, 2'b10);
    cfg_tx_pref = 1'b0;
    for (int k = 0; k < 2; k++) round("R7 fixed rx", 1, 1, 2'b01);
  endtask

  task automatic t_hold();
    do_reset(2'd0, 1'b0, 1'b0);
    tx_req = 1; rx_req = 0;
    @(negedge clk);
    check("R2 grant after one edge", {tx_gnt, rx_gnt}, 2'b10);
    rx_req = 1; rx_done = 1; cfg_fixed = 1; cfg_tx_pref = 0; cfg_ratio = 2'd3;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R4 R9 grant held", {tx_gnt, rx_gnt}, 2'b10);
    end
    rx_done = 0; tx_req = 0; tx_done = 1;
    @(negedge clk);
    tx_done = 0;
    check("R3 drop on done", {tx_gnt, rx_gnt}, 2'b00);
    @(negedge clk);
    check("R9 new config applies", {tx_gnt, rx_gnt}, 2'b01);
    rx_req = 0; rx_done = 1;
    @(negedge clk);
    rx_done = 0;
  endtask

  task automatic t_shrink();
    do_reset(2'd3, 1'b0, 1'b0);
    round("R9 run 1", 1, 1, 2'b01);
    round("R9 run 2", 1, 1, 2'b01);
    cfg_ratio = 2'd0;
    round("R9 shorter limit", 1, 1, 2'b10);
    round("R9 restart", 1, 1, 2'b01);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 0; tx_req = 0; rx_req = 0; tx_done = 0; rx_done = 0;
    cfg_ratio = 0; cfg_tx_pref = 0; cfg_fixed = 0;
    t_reset();
    t_ratio_rx(2'd0);
    t_ratio_rx(2'd1);
    t_ratio_rx(2'd2);
    t_ratio_tx();
    t_uncontested();
    t_fixed();
    t_hold();
    t_shrink();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule